// File: doc/BRIEF.md
# Skyline Filter Chain

This block reduces a stream of multi-dimensional tuples to its skyline. The skyline is the set of tuples that no other tuple in the stream beats. Each tuple arrives as `DIM` unsigned 32-bit components, component 0 first, on a valid/ready input stream. A smaller value is better in every dimension. The tuple passes component by component through a linear chain of `NPE` filter elements, with one register stage per element. Each element holds one window tuple in a single-port store and carries the running comparison flags for the tuple that is passing through it. When the final component reaches an element, that element decides the case. If its stored tuple beats the incoming one, the incoming tuple is marked dead for the rest of the chain. If the incoming tuple beats the stored one, the element frees itself. A tuple that leaves the chain still alive is written, whole and in one cycle, into the free element with the lowest index.

The input accepts one tuple at a time. After the last component of a tuple is taken, `in_ready` stays low until the tuple leaves the chain. An end-of-stream beat (`in_eos` high with `in_valid`) is taken only at a tuple boundary. After it, the block walks the elements in index order. Each occupied element sends its tuple on the output stream, and `out_last` marks the tuple's final component. The output follows the usual valid/ready rules: while `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold. When the walk ends, `done` pulses for one cycle. In that same cycle the window and the overflow flag are cleared, and the block is ready for a new stream.

Top module: `skyline_chain`

## Requirements
- R1: Tuple A dominates B when every component of A is less than or equal to the matching component of B and at least one is strictly less. An incoming tuple dominated by a stored tuple is discarded and never appears on the output.
- R2: A stored tuple dominated by an incoming tuple is removed from the window, and its element becomes free.
- R3: Tuples that do not dominate each other are all kept, including exact duplicates.
- R4: A surviving tuple is stored in the free element with the lowest index. This is checked in the same pass as any removals R2 made.
- R5: A surviving tuple that finds no free element is discarded and `overflow` goes high. `overflow` stays high until the `done` pulse and is low after it.
- R6: After an end-of-stream beat, each occupied element sends its `DIM` components in order of rising element index, with `out_last` high on component `DIM-1` only. Then `done` is high for exactly one cycle, and the window is empty afterwards. An empty window gives `done` with no output beats.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` holds its value into the next cycle.
- R8: `in_ready` is low from the cycle after the last component of a tuple is taken until that tuple has been resolved. It is also low during the output walk. An end-of-stream beat is not taken in the middle of a tuple.
- R9: During and just after reset, `out_valid`, `done` and `overflow` are low and `in_ready` is high.
- R10: Components are compared as unsigned 32-bit magnitudes, so 32'h8000_0000 is larger than 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted on a cycle with in_valid high |
| in_data | input | 32 | Tuple component |
| in_eos | input | 1 | Beat is an end-of-stream marker; in_data is ignored |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Downstream takes the output beat |
| out_data | output | 32 | Skyline tuple component |
| out_last | output | 1 | Final component of the current output tuple |
| done | output | 1 | One-cycle pulse that ends the output walk |
| overflow | output | 1 | A survivor was lost because the window was full |

## Verification
Removal and insertion can happen in the same tuple pass. A tuple that beats stored entries frees their elements on the way down the chain. It must then land in the lowest of those freed elements when it leaves the tail. The bench sets this up by sending a tuple that dominates both occupied elements, followed by an exact duplicate of that tuple. It then checks, through the element-order flush, that the two copies come out of elements 0 and 1. A second stream fills the window, frees one element through dominance, refills it, and then overflows. The bench checks the overflow flag against an independent model after every tuple.

// File: rtl/skyline_pkg.sv
package skyline_pkg;
  localparam int CW = 32;
  typedef logic [CW-1:0] comp_t;
  typedef enum logic [1:0] {SK_RUN, SK_FLUSH, SK_DONE} sk_state_e;
endpackage

// File: rtl/skyline_pe.sv
module skyline_pe
  import skyline_pkg::*;
#(
  parameter int DIM = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  i_v,
  input  comp_t                 i_comp,
  input  logic                  i_last,
  input  logic                  i_alive,
  output logic                  o_v,
  output comp_t                 o_comp,
  output logic                  o_last,
  output logic                  o_alive,
  input  logic                  wr_en,
  input  logic [DIM*CW-1:0]     wr_tuple,
  input  logic                  clr,
  input  logic                  rd_flush,
  input  logic [((DIM > 1) ? $clog2(DIM) : 1)-1:0] rd_idx,
  output comp_t                 rd_data,
  output logic                  occ
);
  localparam int IW = (DIM > 1) ? $clog2(DIM) : 1;

  comp_t          mem [DIM];
  logic           occ_q;
  logic [IW-1:0]  idx_q;
  logic           le_q, lt_q, sle_q, slt_q;
  logic [IW-1:0]  addr;
  comp_t          s;
  logic           le_n, lt_n, sle_n, slt_n;
  logic           dom_in, dom_st;

  // single port: the walk address replaces the compare address while flushing
  assign addr    = rd_flush ? rd_idx : idx_q;
  assign s       = mem[addr];
  assign rd_data = s;
  assign occ     = occ_q;

  assign le_n  = le_q  & (i_comp <= s);
  assign lt_n  = lt_q  | (i_comp <  s);
  assign sle_n = sle_q & (s <= i_comp);
  assign slt_n = slt_q | (s <  i_comp);

  assign dom_in = occ_q & sle_n & slt_n;
  assign dom_st = occ_q & le_n & lt_n & i_alive;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ_q   <= 1'b0;
      idx_q   <= '0;
      le_q    <= 1'b1;
      lt_q    <= 1'b0;
      sle_q   <= 1'b1;
      slt_q   <= 1'b0;
      o_v     <= 1'b0;
      o_comp  <= '0;
      o_last  <= 1'b0;
      o_alive <= 1'b0;
    end else begin
      o_v     <= i_v;
      o_comp  <= i_comp;
      o_last  <= i_last;
      o_alive <= i_alive & ~(i_v & i_last & dom_in);
      if (i_v) begin
        if (i_last) begin
          idx_q <= '0;
          le_q  <= 1'b1;
          lt_q  <= 1'b0;
          sle_q <= 1'b1;
          slt_q <= 1'b0;
          if (dom_st) occ_q <= 1'b0;
        end else begin
          idx_q <= idx_q + IW'(1);
          le_q  <= le_n;
          lt_q  <= lt_n;
          sle_q <= sle_n;
          slt_q <= slt_n;
        end
      end
      if (clr) occ_q <= 1'b0;
      else if (wr_en) occ_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int k = 0; k < DIM; k++) mem[k] <= wr_tuple[k*CW +: CW];
    end
  end

  // R2: an element is freed only when a tuple's final component passes it, or by the walk clear
  a_r2_free_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(occ_q) |-> $past(clr || (i_v && i_last)));

  // R4: the tail writes only into an element that is free
  a_r4_write_free: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !occ_q);
endmodule

// File: rtl/skyline_tail.sv
module skyline_tail
  import skyline_pkg::*;
#(
  parameter int DIM = 6,
  parameter int NPE = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              i_v,
  input  comp_t             i_comp,
  input  logic              i_last,
  input  logic              i_alive,
  input  logic [NPE-1:0]    free,
  output logic [NPE-1:0]    wr_sel,
  output logic [DIM*CW-1:0] wr_tuple,
  output logic              done_t,
  output logic              ovf_set
);
  localparam int IW = (DIM > 1) ? $clog2(DIM) : 1;

  comp_t          buf_q [DIM];
  logic [IW-1:0]  cnt_q;
  logic [NPE-1:0] first_free;
  logic           found;
  logic           fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (i_v) cnt_q <= i_last ? '0 : cnt_q + IW'(1);
  end

  always_ff @(posedge clk) begin
    if (i_v) buf_q[cnt_q] <= i_comp;
  end

  always_comb begin
    for (int k = 0; k < DIM - 1; k++) wr_tuple[k*CW +: CW] = buf_q[k];
    wr_tuple[(DIM-1)*CW +: CW] = i_comp;
  end

  always_comb begin
    first_free = '0;
    found      = 1'b0;
    for (int i = 0; i < NPE; i++) begin
      if (free[i] && !found) begin
        first_free[i] = 1'b1;
        found         = 1'b1;
      end
    end
  end

  assign fire    = i_v & i_last & i_alive;
  assign wr_sel  = fire ? first_free : '0;
  assign ovf_set = fire & ~(|free);
  assign done_t  = i_v & i_last;

  // R4: at most one element receives a survivor
  a_r4_single_write: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_sel));
endmodule

// File: rtl/skyline_chain.sv
module skyline_chain
  import skyline_pkg::*;
#(
  parameter int DIM = 6,
  parameter int NPE = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  output logic        in_ready,
  input  logic [31:0] in_data,
  input  logic        in_eos,
  output logic        out_valid,
  input  logic        out_ready,
  output logic [31:0] out_data,
  output logic        out_last,
  output logic        done,
  output logic        overflow
);
  localparam int IW = (DIM > 1) ? $clog2(DIM) : 1;
  localparam int PW = $clog2(NPE + 1);

  sk_state_e      state_q;
  logic           busy_q, ovf_q;
  logic [IW-1:0]  ccnt_q, fc_q;
  logic [PW-1:0]  fp_q;

  logic [NPE:0]   sv, sl, sa;
  comp_t          sc [NPE+1];
  comp_t          rdata [NPE];
  logic [NPE-1:0] occ, wr_sel;
  logic [DIM*CW-1:0] wr_tuple;
  logic           tail_done, ovf_set;
  logic           take_comp, take_eos, comp_last, fc_last, flushing, clr;
  logic           cur_occ;
  comp_t          cur_data;

  assign in_ready  = (state_q == SK_RUN) & ~busy_q & (~in_eos | (ccnt_q == '0));
  assign take_comp = in_valid & in_ready & ~in_eos;
  assign take_eos  = in_valid & in_ready & in_eos;
  assign comp_last = (ccnt_q == IW'(DIM - 1));
  assign fc_last   = (fc_q == IW'(DIM - 1));
  assign flushing  = (state_q == SK_FLUSH);
  assign clr       = (state_q == SK_DONE);

  assign sv[0] = take_comp;
  assign sc[0] = in_data;
  assign sl[0] = comp_last;
  assign sa[0] = 1'b1;

  for (genvar g = 0; g < NPE; g++) begin : g_pe
    skyline_pe #(.DIM(DIM)) u_pe (
      .clk      (clk),
      .rst_n    (rst_n),
      .i_v      (sv[g]),
      .i_comp   (sc[g]),
      .i_last   (sl[g]),
      .i_alive  (sa[g]),
      .o_v      (sv[g+1]),
      .o_comp   (sc[g+1]),
      .o_last   (sl[g+1]),
      .o_alive  (sa[g+1]),
      .wr_en    (wr_sel[g]),
      .wr_tuple (wr_tuple),
      .clr      (clr),
      .rd_flush (flushing),
      .rd_idx   (fc_q),
      .rd_data  (rdata[g]),
      .occ      (occ[g])
    );
  end

  skyline_tail #(.DIM(DIM), .NPE(NPE)) u_tail (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_v      (sv[NPE]),
    .i_comp   (sc[NPE]),
    .i_last   (sl[NPE]),
    .i_alive  (sa[NPE]),
    .free     (~occ),
    .wr_sel   (wr_sel),
    .wr_tuple (wr_tuple),
    .done_t   (tail_done),
    .ovf_set  (ovf_set)
  );

  always_comb begin
    cur_occ  = 1'b0;
    cur_data = '0;
    for (int i = 0; i < NPE; i++) begin
      if (fp_q == PW'(i)) begin
        cur_occ  = occ[i];
        cur_data = rdata[i];
      end
    end
  end

  assign out_valid = flushing & cur_occ;
  assign out_data  = cur_data;
  assign out_last  = fc_last;
  assign done      = clr;
  assign overflow  = ovf_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SK_RUN;
      busy_q  <= 1'b0;
      ovf_q   <= 1'b0;
      ccnt_q  <= '0;
      fc_q    <= '0;
      fp_q    <= '0;
    end else begin
      if (tail_done) busy_q <= 1'b0;
      if (ovf_set)   ovf_q  <= 1'b1;
      unique case (state_q)
        SK_RUN: begin
          if (take_comp) begin
            if (comp_last) begin
              ccnt_q <= '0;
              busy_q <= 1'b1;
            end else begin
              ccnt_q <= ccnt_q + IW'(1);
            end
          end
          if (take_eos) begin
            state_q <= SK_FLUSH;
            fp_q    <= '0;
            fc_q    <= '0;
          end
        end
        SK_FLUSH: begin
          if (fp_q == PW'(NPE)) state_q <= SK_DONE;
          else if (!cur_occ) fp_q <= fp_q + PW'(1);
          else if (out_ready) begin
            if (fc_last) begin
              fc_q <= '0;
              fp_q <= fp_q + PW'(1);
            end else begin
              fc_q <= fc_q + IW'(1);
            end
          end
        end
        SK_DONE: begin
          state_q <= SK_RUN;
          ovf_q   <= 1'b0;
        end
        default: state_q <= SK_RUN;
      endcase
    end
  end

  // R7: a stalled output beat holds
  a_r7_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R6: the window is empty after the done pulse
  a_r6_done_empties: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (occ == '0));

  // R6: done only follows the output walk
  a_r6_done_after_walk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(state_q == SK_FLUSH));

  // R5: overflow is sticky until the done pulse
  a_r5_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !done |=> overflow);
endmodule

// File: tb/test_skyline_chain.sv
module test_skyline_chain;
  localparam int DIM = 3;
  localparam int NPE = 4;
  localparam int NV  = 15;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_eos = 1'b0, out_ready = 1'b0;
  logic [31:0] in_data = '0;
  logic        in_ready, out_valid, out_last, done, overflow;
  logic [31:0] out_data;

  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  skyline_chain #(.DIM(DIM), .NPE(NPE)) i_skyline_chain (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_eos(in_eos), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .done(done), .overflow(overflow));

  // bit 96 = end of stream; bits 95:64 = comp0, 63:32 = comp1, 31:0 = comp2
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 32'd5, 32'd5, 32'd5},          // stored in element 0
    {1'b0, 32'd6, 32'd6, 32'd6},          // R1 dominated, dropped
    {1'b0, 32'd3, 32'd7, 32'd5},          // R3 incomparable, element 1
    {1'b0, 32'd2, 32'd2, 32'd2},          // R2 frees 0 and 1, R4 lands in 0
    {1'b0, 32'd2, 32'd2, 32'd2},          // R3 duplicate kept in 1
    {1'b0, 32'd1, 32'd9, 32'd9},          // element 2
    {1'b0, 32'h8000_0000, 32'd0, 32'd0},  // R10 unsigned: incomparable
    {1'b1, 96'd0},
    {1'b0, 32'd1, 32'd4, 32'd4},
    {1'b0, 32'd4, 32'd1, 32'd4},
    {1'b0, 32'd4, 32'd4, 32'd1},
    {1'b0, 32'd2, 32'd2, 32'd3},
    {1'b0, 32'd3, 32'd3, 32'd0},          // R2 frees element 2, refills it
    {1'b0, 32'd0, 32'd5, 32'd5},          // R5 window full, overflow
    {1'b1, 96'd0}
  };

  logic [31:0] m_st [NPE][DIM];
  bit          m_occ [NPE];
  bit          m_ovf;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit dom(input logic [31:0] a [DIM], input logic [31:0] b [DIM]);
    bit le = 1'b1, lt = 1'b0;
    for (int k = 0; k < DIM; k++) begin
      if (a[k] > b[k]) le = 1'b0;
      if (a[k] < b[k]) lt = 1'b1;
    end
    return le && lt;
  endfunction

  task automatic model_tuple(input logic [31:0] t [DIM]);
    bit killed = 1'b0, placed = 1'b0;
    for (int i = 0; i < NPE; i++) if (m_occ[i] && dom(m_st[i], t)) killed = 1'b1;
    if (!killed) begin
      for (int i = 0; i < NPE; i++) if (m_occ[i] && dom(t, m_st[i])) m_occ[i] = 1'b0;
      for (int i = 0; i < NPE; i++) begin
        if (!m_occ[i] && !placed) begin
          m_occ[i] = 1'b1;
          placed = 1'b1;
          for (int k = 0; k < DIM; k++) m_st[i][k] = t[k];
        end
      end
      if (!placed) m_ovf = 1'b1;
    end
  endtask

  // called and returns at a falling edge
  task automatic put(input logic [31:0] d, input bit e);
    in_valid = 1'b1; in_data = d; in_eos = e;
    #1;
    while (!in_ready) begin @(negedge clk); #1; end
    @(posedge clk); #1;
    in_valid = 1'b0; in_eos = 1'b0;
    @(negedge clk);
  endtask

  task automatic send_tuple(input logic [31:0] t [DIM]);
    for (int k = 0; k < DIM; k++) put(t[k], 1'b0);
    chk(in_ready == 1'b0, "R8 busy after tuple", 32'(in_ready), 0);
    while (!in_ready) @(negedge clk);
    model_tuple(t);
    chk(overflow == m_ovf, "R5 overflow flag", 32'(overflow), 32'(m_ovf));
  endtask

  task automatic flush_check();
    logic [31:0] got [NPE][DIM];
    logic [31:0] prev_data = '0;
    int beats = 0, guard = 0, exp_n = 0, j = 0;
    bit seen_done = 1'b0, prev_stall = 1'b0, first = 1'b1;
    put(32'd0, 1'b1);
    while (!seen_done && guard < 2000) begin
      if (done) seen_done = 1'b1;
      else begin
        if (first) begin
          chk(in_ready == 1'b0, "R8 ready low during walk", 32'(in_ready), 0);
          first = 1'b0;
        end
        if (prev_stall)
          chk(out_valid && out_data == prev_data, "R7 stalled beat holds", out_data, prev_data);
        out_ready = (guard % 3) != 1;
        if (out_valid && out_ready) begin
          if (beats < NPE*DIM) got[beats/DIM][beats%DIM] = out_data;
          chk(out_last == ((beats % DIM) == DIM-1), "R6 out_last position", 32'(out_last), 32'((beats % DIM) == DIM-1));
          beats++;
        end
        prev_stall = out_valid && !out_ready;
        prev_data  = out_data;
        @(negedge clk);
        guard++;
      end
    end
    out_ready = 1'b0;
    chk(seen_done, "R6 done pulse", 32'(seen_done), 1);
    for (int i = 0; i < NPE; i++) if (m_occ[i]) exp_n++;
    chk(beats == exp_n*DIM, "R6 beat count", beats, exp_n*DIM);
    for (int i = 0; i < NPE; i++) begin
      if (m_occ[i] && j < beats/DIM) begin
        for (int k = 0; k < DIM; k++)
          chk(got[j][k] == m_st[i][k], "R1 R2 R3 R4 R10 skyline content and order", got[j][k], m_st[i][k]);
        j++;
      end
    end
    @(negedge clk);
    chk(done == 1'b0, "R6 done lasts one cycle", 32'(done), 0);
    chk(overflow == 1'b0 && in_ready == 1'b1, "R5 R6 cleared after done", {30'd0, overflow, in_ready}, 1);
    for (int i = 0; i < NPE; i++) m_occ[i] = 1'b0;
    m_ovf = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] t [DIM];
    for (int i = 0; i < NPE; i++) m_occ[i] = 1'b0;
    m_ovf = 1'b0;
    repeat (3) @(negedge clk);
    chk(out_valid == 0 && done == 0 && overflow == 0, "R9 outputs in reset", {29'd0, out_valid, done, overflow}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1'b1 && out_valid == 1'b0, "R9 ready after reset", {30'd0, in_ready, out_valid}, 2);

    // R6 boundary: empty window gives done with no beats
    flush_check();

    for (int v = 0; v < NV; v++) begin
      if (VEC[v][96]) flush_check();
      else begin
        for (int k = 0; k < DIM; k++) t[k] = VEC[v][(DIM-1-k)*32 +: 32];
        send_tuple(t);
      end
    end

    // R8: end-of-stream in the middle of a tuple is held off
    put(32'd7, 1'b0);
    in_valid = 1'b1; in_eos = 1'b1; #1;
    chk(in_ready == 1'b0, "R8 eos refused mid-tuple", 32'(in_ready), 0);
    @(negedge clk); #1;
    chk(in_ready == 1'b0, "R8 eos still refused", 32'(in_ready), 0);
    in_valid = 1'b0; in_eos = 1'b0;
    @(negedge clk);
    put(32'd7, 1'b0);
    put(32'd7, 1'b0);
    while (!in_ready) @(negedge clk);
    t[0] = 32'd7; t[1] = 32'd7; t[2] = 32'd7;
    model_tuple(t);
    flush_check();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule